// File: doc/BRIEF.md
# Multi-Lane Timestamped Event Sequencer

This block takes timestamped output events from one producer and distributes them over a small set of lane FIFOs. Each event carries a coarse timestamp, a fine sub-cycle offset, a channel number and a data word. Inside any one lane the coarse timestamps must strictly increase. Because several lanes exist, the producer may step its timeline backwards, or issue several events with the same coarse time, without any sorting hardware. The sequencer keeps a rotating lane pointer and the last coarse timestamp written to each lane.

When an event cannot follow the current lane, it tries the lane after it, wrapping from the highest lane to lane 0. If that lane cannot take the event either, the event is dropped and a sticky sequence-error flag records the channel of the first dropped event. A full target lane does not cause an error. Instead the input is held off until a slot frees. A downstream arbiter, which is not part of this block, reads the head of every lane and pops the entries it executes.

The outcome for any sequence depends only on the differences between timestamps. A lane that has not been written since reset accepts any timestamp. Adding the same offset to every timestamp in a sequence therefore gives the same result.

Top module: `event_lane_sequencer`

## Requirements
- R1: The coarse timestamps stored in any one lane, read out in order, strictly increase.
- R2: An event whose coarse timestamp is greater than the last value written to the lane under the pointer, or that arrives when that lane has not been written since reset, is stored in that lane and the pointer stays.
- R3: An event whose coarse timestamp is less than or equal to the current lane's last value goes to the next lane (index + 1, with the highest lane wrapping to lane 0). The pointer then moves to that lane.
- R4: If the next lane has been written and its last value is greater than or equal to the incoming coarse timestamp, the event is discarded. It is taken (in_ready high) but stored in no lane, and the pointer and the per-lane last values are left unchanged.
- R5: After a discarded event, later events are accepted and placed by the same rules.
- R6: Successive events with equal coarse timestamps occupy successive lanes. Once every lane holds that time, the next such event is discarded.
- R7: Lane decisions use the coarse timestamp only. The fine field is stored and presented, but it never affects placement.
- R8: When the target lane is full, in_ready is low, the event is neither stored nor discarded, and no sequence error is raised. It is accepted once the arbiter pops that lane.
- R9: seq_err rises on the first discarded event and stays high until reset. seq_err_chan holds the channel of that first discarded event and does not change on later discards.
- R10: After reset, all lanes are empty, the pointer is at lane 0, no lane counts as written, seq_err is 0 and seq_err_chan is 0.
- R11: Adding the same constant to every coarse timestamp in a sequence started from reset does not change which events are stored, in which lanes, or which are discarded.
- R12: Each lane presents its oldest entry on its head outputs, with head_valid bit k high when lane k is not empty. A pulse on head_pop bit k removes that entry, and entries leave each lane in the order they arrived. Head buses pack lane k at bits [k*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming event present |
| in_ready | output | 1 | Event taken this cycle (stored or discarded) |
| in_coarse | input | 64 | Coarse timestamp of the event |
| in_fine | input | 3 | Fine sub-cycle offset |
| in_chan | input | 8 | Target channel number |
| in_data | input | 32 | Event payload |
| head_valid | output | 4 | Per-lane non-empty flags |
| head_coarse | output | 256 | Per-lane head coarse timestamps |
| head_fine | output | 12 | Per-lane head fine offsets |
| head_chan | output | 32 | Per-lane head channel numbers |
| head_data | output | 128 | Per-lane head payloads |
| head_pop | input | 4 | Per-lane pop strobes from the arbiter |
| seq_err | output | 1 | Sticky sequence-error flag |
| seq_err_chan | output | 8 | Channel of the first discarded event |

## Verification
The assertions assume that the producer holds the event fields steady while in_valid is high and in_ready is low. They also assume that head_pop is raised only for lanes whose head_valid is set. The bench meets both conditions by changing its inputs only on falling edges after a handshake has completed, and by popping a lane only while its head is valid. The main sweep covers every four-event pattern of coarse values 0 to 3. Each pattern is run once from zero and once shifted by a large offset, with the fine field varied throughout. The lane contents and error state are compared against a placement model computed in the bench. Directed runs add wrap-around, five equal timestamps, discard-then-continue, and a stall on a full lane.

// File: rtl/seq_pkg.sv
package seq_pkg;

    parameter int TS_W   = 64;
    parameter int FINE_W = 3;
    parameter int CHAN_W = 8;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic [TS_W-1:0]   coarse;
        logic [FINE_W-1:0] fine;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } seq_event_t;

    // successor lane with wrap to zero
    function automatic int unsigned succ_lane(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/seq_lane_fifo.sv
module seq_lane_fifo
    import seq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  seq_event_t push_ev,
    input  logic       pop,
    output seq_event_t head_ev,
    output logic       head_valid,
    output logic       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    seq_event_t     mem [DEPTH];
    logic [AW-1:0]  wr_idx, rd_idx;
    logic [CW-1:0]  level;
    logic           do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] i);
        return (i == AW'(DEPTH - 1)) ? '0 : i + AW'(1);
    endfunction

    assign head_valid = (level != '0);
    assign full       = (level == CW'(DEPTH));
    assign head_ev    = mem[rd_idx];
    assign do_pop     = pop && head_valid;

    always_ff @(posedge clk) begin
        if (push) mem[wr_idx] <= push_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            level  <= '0;
        end else begin
            if (push)   wr_idx <= bump(wr_idx);
            if (do_pop) rd_idx <= bump(rd_idx);
            case ({push, do_pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    // R8: the selector never writes into a full lane
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R1: the next head after a pop carries a strictly later coarse time
    assert_head_increasing_R1: assert property (@(posedge clk) disable iff (rst)
        (do_pop && level >= CW'(2)) |=> (head_ev.coarse > $past(head_ev.coarse)));

endmodule

// File: rtl/seq_lane_select.sv
module seq_lane_select
    import seq_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LW        = 2
) (
    input  logic [LW-1:0]                    ptr,
    input  logic [TS_W-1:0]                  coarse,
    input  logic [NUM_LANES-1:0][TS_W-1:0]   last_ts,
    input  logic [NUM_LANES-1:0]             written,
    input  logic [NUM_LANES-1:0]             lane_full,
    output logic [LW-1:0]                    target,
    output logic                             reject,
    output logic                             target_full
);
    logic [LW-1:0] nxt;
    logic          cur_ok, nxt_ok;

    always_comb begin
        nxt    = LW'(succ_lane(int'(ptr), NUM_LANES));
        cur_ok = !written[ptr] || (coarse > last_ts[ptr]);
        nxt_ok = !written[nxt] || (coarse > last_ts[nxt]);
        target = cur_ok ? ptr : nxt;
        reject = !cur_ok && !nxt_ok;
        target_full = lane_full[target];
    end

endmodule

// File: rtl/event_lane_sequencer.sv
module event_lane_sequencer
    import seq_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int LANE_DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [TS_W-1:0]               in_coarse,
    input  logic [FINE_W-1:0]             in_fine,
    input  logic [CHAN_W-1:0]             in_chan,
    input  logic [DATA_W-1:0]             in_data,
    output logic [NUM_LANES-1:0]          head_valid,
    output logic [NUM_LANES*TS_W-1:0]     head_coarse,
    output logic [NUM_LANES*FINE_W-1:0]   head_fine,
    output logic [NUM_LANES*CHAN_W-1:0]   head_chan,
    output logic [NUM_LANES*DATA_W-1:0]   head_data,
    input  logic [NUM_LANES-1:0]          head_pop,
    output logic                          seq_err,
    output logic [CHAN_W-1:0]             seq_err_chan
);
    localparam int LW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic [LW-1:0]                  ptr_q;
    logic [NUM_LANES-1:0][TS_W-1:0] last_q;
    logic [NUM_LANES-1:0]           written_q;
    logic [NUM_LANES-1:0]           lane_full;
    logic [LW-1:0]                  target;
    logic                           reject, target_full;
    logic                           accept, discard;
    seq_event_t                     in_ev;

    assign in_ev = '{coarse: in_coarse, fine: in_fine, chan: in_chan, data: in_data};

    seq_lane_select #(.NUM_LANES(NUM_LANES), .LW(LW)) u_select (
        .ptr        (ptr_q),
        .coarse     (in_coarse),
        .last_ts    (last_q),
        .written    (written_q),
        .lane_full  (lane_full),
        .target     (target),
        .reject     (reject),
        .target_full(target_full)
    );

    assign in_ready = reject || !target_full;
    assign accept   = in_valid && !reject && !target_full;
    assign discard  = in_valid && reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            last_q    <= '0;
            written_q <= '0;
        end else if (accept) begin
            ptr_q             <= target;
            last_q[target]    <= in_coarse;
            written_q[target] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_err      <= 1'b0;
            seq_err_chan <= '0;
        end else if (discard && !seq_err) begin
            seq_err      <= 1'b1;
            seq_err_chan <= in_chan;
        end
    end

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        seq_event_t h_ev;
        logic       lane_push;

        assign lane_push = accept && (target == LW'(k));

        seq_lane_fifo #(.DEPTH(LANE_DEPTH)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (lane_push),
            .push_ev   (in_ev),
            .pop       (head_pop[k]),
            .head_ev   (h_ev),
            .head_valid(head_valid[k]),
            .full      (lane_full[k])
        );

        assign head_coarse[k*TS_W +: TS_W]     = h_ev.coarse;
        assign head_fine[k*FINE_W +: FINE_W]   = h_ev.fine;
        assign head_chan[k*CHAN_W +: CHAN_W]   = h_ev.chan;
        assign head_data[k*DATA_W +: DATA_W]   = h_ev.data;
    end

    // R9: error flag and captured channel hold once set
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> (seq_err && $stable(seq_err_chan)));

    // R4: a discarded event leaves pointer and lane history untouched
    assert_discard_keeps_state_R4: assert property (@(posedge clk) disable iff (rst)
        discard |=> ($stable(ptr_q) && $stable(last_q) && $stable(written_q)));

    // R8: a stalled event changes nothing and raises no error
    assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> ($stable(ptr_q) && $stable(written_q) && $stable(seq_err)));

    // R3: the pointer only moves by one lane (with wrap)
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr_q) |-> (ptr_q == LW'(succ_lane(int'($past(ptr_q)), NUM_LANES))));

endmodule

// File: tb/event_lane_sequencer_tb.sv
`timescale 1ns/1ps
module event_lane_sequencer_tb;
    localparam int N = 4;
    localparam int D = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [63:0]       in_coarse = '0;
    logic [2:0]        in_fine = '0;
    logic [7:0]        in_chan = '0;
    logic [31:0]       in_data = '0;
    logic [N-1:0]      head_valid;
    logic [N*64-1:0]   head_coarse;
    logic [N*3-1:0]    head_fine;
    logic [N*8-1:0]    head_chan;
    logic [N*32-1:0]   head_data;
    logic [N-1:0]      head_pop = '0;
    logic              seq_err;
    logic [7:0]        seq_err_chan;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    event_lane_sequencer #(.NUM_LANES(N), .LANE_DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coarse(in_coarse), .in_fine(in_fine), .in_chan(in_chan), .in_data(in_data),
        .head_valid(head_valid), .head_coarse(head_coarse), .head_fine(head_fine),
        .head_chan(head_chan), .head_data(head_data), .head_pop(head_pop),
        .seq_err(seq_err), .seq_err_chan(seq_err_chan)
    );

    // placement model derived from the requirements
    logic [63:0] m_last [N];
    bit          m_wr   [N];
    int          m_ptr;
    logic [63:0] m_q    [N][10];
    logic [7:0]  m_qc   [N][10];
    int          m_cnt  [N];
    int          m_err_chan;

    task automatic model_reset();
        for (int k = 0; k < N; k++) begin m_last[k] = '0; m_wr[k] = 0; m_cnt[k] = 0; end
        m_ptr = 0;
        m_err_chan = 0;
    endtask

    task automatic model_put(input logic [63:0] c, input logic [7:0] ch);
        int  nx;
        bit  cur_ok, nx_ok;
        int  t;
        nx = (m_ptr + 1) % N;
        cur_ok = !m_wr[m_ptr] || (c > m_last[m_ptr]);
        nx_ok  = !m_wr[nx] || (c > m_last[nx]);
        if (!cur_ok && !nx_ok) begin
            if (m_err_chan == 0) m_err_chan = int'(ch);
        end else begin
            t = cur_ok ? m_ptr : nx;
            m_ptr = t; m_last[t] = c; m_wr[t] = 1;
            m_q[t][m_cnt[t]] = c; m_qc[t][m_cnt[t]] = ch; m_cnt[t]++;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; head_pop = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic send(input logic [63:0] c, input logic [2:0] f, input logic [7:0] ch);
        @(negedge clk);
        in_valid = 1'b1; in_coarse = c; in_fine = f; in_chan = ch; in_data = {24'h0, ch};
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // pop every lane and compare to the model, offsets removed
    task automatic drain_compare(input logic [63:0] base, input string req);
        for (int k = 0; k < N; k++) begin
            bit ok = 1;
            longint bad_a = 0, bad_e = 0;
            for (int e = 0; e < m_cnt[k]; e++) begin
                @(negedge clk);
                if (!head_valid[k] || head_coarse[k*64 +: 64] != base + m_q[k][e]
                    || head_chan[k*8 +: 8] != m_qc[k][e]) begin
                    if (ok) begin
                        bad_a = longint'(head_coarse[k*64 +: 64] - base);
                        bad_e = longint'(m_q[k][e]);
                    end
                    ok = 0;
                end
                head_pop[k] = 1'b1;
                @(negedge clk);
                head_pop[k] = 1'b0;
            end
            @(negedge clk);
            if (head_valid[k]) ok = 0;
            check(ok, req, $sformatf("lane %0d contents", k), bad_a, bad_e);
        end
    endtask

    task automatic run_seq(input logic [63:0] vals[10], input int len,
                           input logic [63:0] base, input string req);
        do_reset();
        for (int i = 0; i < len; i++) begin
            send(base + vals[i], 3'(i * 3 + 1), 8'(i + 1));
            model_put(vals[i], 8'(i + 1));
        end
        @(negedge clk);
        check(seq_err == (m_err_chan != 0) && int'(seq_err_chan) == m_err_chan,
              "R4/R9", "error flag/channel", {seq_err, seq_err_chan}, m_err_chan);
        drain_compare(base, req);
    endtask

    initial begin
        logic [63:0] v [10];

        // R10: reset state
        do_reset();
        @(negedge clk);
        check(head_valid == '0, "R10", "head_valid after reset", head_valid, 0);
        check(!seq_err && seq_err_chan == 0, "R10", "error state after reset", seq_err, 0);
        check(in_ready == 1'b1, "R10", "ready after reset", in_ready, 1);

        // R7: equal coarse, different fine -> separate lanes
        send(64'd5, 3'd0, 8'd1);
        send(64'd5, 3'd7, 8'd2);
        @(negedge clk);
        check(head_valid == 4'b0011, "R7", "fine ignored, lanes used", head_valid, 3);
        check(head_fine[5:3] == 3'd7, "R7", "fine stored in lane 1", head_fine[5:3], 7);

        // R6/R5/R9: five equal times, then continue, then a second discard
        do_reset();
        for (int i = 0; i < 5; i++) send(64'd50, 3'd0, 8'(10 + i));
        @(negedge clk);
        check(head_valid == 4'b1111, "R6", "four lanes hold equal time", head_valid, 15);
        check(seq_err && seq_err_chan == 8'd14, "R6", "fifth equal event discarded", seq_err_chan, 14);
        send(64'd51, 3'd0, 8'd20);
        send(64'd1, 3'd0, 8'd21);
        @(negedge clk);
        check(seq_err_chan == 8'd14, "R9", "first channel kept", seq_err_chan, 14);
        head_pop[3] = 1'b1; @(negedge clk); head_pop[3] = 1'b0; @(negedge clk);
        check(head_valid[3] && head_coarse[3*64 +: 64] == 64'd51, "R5",
              "event after discard accepted", head_coarse[3*64 +: 64], 51);

        // R3: wrap from the last lane back to lane 0
        v = '{64'd1, 64'd0, 64'd0, 64'd0, 64'd5, 64'd4, 64'd2, 64'd9, 64'd0, 64'd0};
        run_seq(v, 8, 64'd0, "R3 wrap");

        // R8/R12: stall on a full lane
        do_reset();
        for (int i = 0; i < D; i++) send(64'(10 + i), 3'd0, 8'(i + 1));
        @(negedge clk);
        in_valid = 1'b1; in_coarse = 64'd18; in_chan = 8'd99; in_fine = 3'd2;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check(!in_ready, "R8", "ready low on full lane", in_ready, 0);
        check(!seq_err, "R8", "no error on stall", seq_err, 0);
        head_pop[0] = 1'b1; @(negedge clk); head_pop[0] = 1'b0;
        #1;
        check(in_ready, "R8", "ready after pop", in_ready, 1);
        @(negedge clk); in_valid = 1'b0;
        begin
            bit ok = 1;
            for (int e = 0; e < D; e++) begin
                @(negedge clk);
                if (!head_valid[0] || head_coarse[63:0] != 64'(11 + e)) ok = 0;
                head_pop[0] = 1'b1; @(negedge clk); head_pop[0] = 1'b0;
            end
            @(negedge clk);
            check(ok && !head_valid[0], "R12", "lane 0 FIFO order after stall", head_valid[0], 0);
        end

        // R1 R2 R3 R4 R6 R7 sweep, then R11 with a large offset
        for (int s = 0; s < 256; s++) begin
            for (int i = 0; i < 4; i++) v[i] = 64'((s >> (2 * i)) & 3);
            run_seq(v, 4, 64'd0, "R1/R2/R3/R4 sweep");
            run_seq(v, 4, 64'h0000_0100_0000_0000 + 64'(s * 977), "R11 offset");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule